// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Controller

This block arbitrates the interrupt sources of a two-channel serial controller, channel A and channel B, and drives one shared active-high interrupt line. Each channel has three sources: a received byte, an emptied transmit buffer and a break condition. For its receive and transmit sources a channel keeps a pending flag and an in-service flag. A transmit request is not presented while the same channel's receive request is in service. When the CPU clears one source, the other pending source of that channel is presented again at once.

Besides the line, the block holds a pending-summary byte and an interrupt vector byte for the host to read. One option input selects which of two vector encodings is used. Event strobes come from the surrounding data path. Host commands arrive as a 3-bit code together with a per-channel write strobe. Configuration bits (enables and receive mode) are inputs held by an external register file. All state is updated on the clock edge.

Top module: `dual_irq_ctrl`

## Requirements
- R1: `irq` is registered. After every edge it equals the OR over both channels of three terms: (`tx_int_en` and transmit pending), (receive mode `01` or `10` and receive pending), (`brk_int_en` and `brk_status`). Receive modes `00` and `11` never request.
- R2: A byte-received strobe sets receive pending and receive in-service in the same edge. It also sets the channel's receive summary bit and loads the receive vector.
- R3: A transmit-empty strobe sets transmit pending. The transmit source is presented (in-service set, vector loaded) only when receive is not in service.
- R4: The summary bits are: bit 5 A receive, bit 4 A transmit, bit 2 B receive, bit 1 B transmit. All other bits are 0. A transmit summary bit is set only while that channel's `tx_int_en` is 1.
- R5: With `vec_status_hi`=1 the vector is 0x30 (A receive), 0x10 (A transmit), 0x20 (B receive) and 0x60 (cleared). With `vec_status_hi`=0 the same cases give 0x0C, 0x08, 0x04 and 0x06. B transmit gives 0x00 in both encodings.
- R6: Command code 3'b111 clears receive in-service if it is set, then presents a pending transmit. Otherwise it clears transmit in-service.
- R7: Command code 3'b101 clears transmit pending, transmit in-service and the transmit summary bit, and loads the cleared vector. It then presents a pending receive again.
- R8: A data-read strobe clears receive pending, receive in-service and the receive summary bit, and loads the cleared vector. It then presents a pending transmit.
- R9: A data-write strobe clears transmit pending and leaves the summary and vector unchanged.
- R10: Within one channel and one cycle, events apply in this order: byte received, data read, data write, transmit empty, command. Receive is therefore handled before transmit.
- R11: When both channels update the vector in one cycle, the new value is chosen by this priority: a presentation by A, then a presentation by B, then a clear by A, then a clear by B.
- R12: During reset and on the first edge after it, `irq` is 0, the summary is 0x00 and the vector is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_byte_ev | input | 2 | Byte received strobe, bit 0 A, bit 1 B |
| data_rd_ev | input | 2 | Receive data read strobe |
| data_wr_ev | input | 2 | Transmit data write strobe |
| tx_empty_ev | input | 2 | Transmit buffer emptied strobe |
| cmd_wr | input | 2 | Command write strobe per channel |
| cmd_code | input | 3 | Command field (3'b101, 3'b111 act; others ignored) |
| tx_int_en | input | 2 | Transmit interrupt enable per channel |
| rx_int_mode | input | 4 | Receive interrupt mode, [1:0] A, [3:2] B |
| brk_int_en | input | 2 | Break interrupt enable per channel |
| brk_status | input | 2 | Break status level per channel |
| vec_status_hi | input | 1 | Selects the high vector encoding |
| irq | output | 1 | Shared interrupt request, active high |
| int_summary | output | 8 | Pending-summary byte |
| int_vector | output | 8 | Interrupt vector byte |

## Verification
A stuck or stale in-service flag shows up on the first clearing action. It leaves the vector on a receive code when it should move to a transmit code, or the reverse. The wrong value appears one edge after the command or read. A pending flag that is lost or stuck shows on `irq` one edge after the event. A wrong summary bit is visible in the same cycle as the vector. The stimulus therefore places each clearing action and each same-cycle collision directly before a sample of all three outputs.

// File: rtl/dual_irq_pkg.sv
// Shared types and constants for the dual-channel interrupt controller.
// Assumes exactly two channels: index 0 is channel A, index 1 is channel B.
package dual_irq_pkg;
    localparam int NCH    = 2;
    localparam int CMD_W  = 3;
    localparam int VEC_W  = 8;
    localparam int SUM_W  = 8;
    localparam int MODE_W = 2;

    localparam logic [CMD_W-1:0] CMD_CLR_TX  = 3'b101;
    localparam logic [CMD_W-1:0] CMD_RST_IUS = 3'b111;

    // Summary bit positions per channel (decoded by host software).
    localparam int SUM_RX_BIT [NCH] = '{5, 2};
    localparam int SUM_TX_BIT [NCH] = '{4, 1};

    // Vector update requested by a channel in one cycle.
    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_IDLE = 2'd1,
        ACT_RX   = 2'd2,
        ACT_TX   = 2'd3
    } vec_act_t;

    // Vector value for a channel, an action and the encoding option.
    function automatic logic [VEC_W-1:0] vec_code(input logic ch_b,
                                                  input vec_act_t act,
                                                  input logic hi);
        case (act)
            ACT_RX:  vec_code = ch_b ? (hi ? 8'h20 : 8'h04) : (hi ? 8'h30 : 8'h0C);
            ACT_TX:  vec_code = ch_b ? 8'h00 : (hi ? 8'h10 : 8'h08);
            default: vec_code = hi ? 8'h60 : 8'h06;
        endcase
    endfunction
endpackage

// File: rtl/irq_chan_state.sv
// Per-channel interrupt state: receive/transmit pending and in-service flags
// plus the two summary bits. Applies same-cycle events in a fixed order
// (receive, read, write, transmit empty, command) and reports the vector action
// and the next-state request term. Assumes strobes are single-cycle pulses.
module irq_chan_state
    import dual_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_rx,
    input  logic              ev_rd,
    input  logic              ev_wr,
    input  logic              ev_txe,
    input  logic              ev_cmd,
    input  logic [CMD_W-1:0]  cmd,
    input  logic              tx_ie,
    input  logic [MODE_W-1:0] rx_mode,
    input  logic              brk_ie,
    input  logic              brk,
    output vec_act_t          act,
    output logic              req_nxt,
    output logic              sum_rx,
    output logic              sum_tx
);
    logic rx_pend_q, rx_svc_q, tx_pend_q, tx_svc_q;
    logic rp, rs, tp, ts, srx, stx;

    // Sequential walk through this cycle's events to form next state.
    always_comb begin
        rp  = rx_pend_q;
        rs  = rx_svc_q;
        tp  = tx_pend_q;
        ts  = tx_svc_q;
        srx = sum_rx;
        stx = sum_tx;
        act = ACT_NONE;
        if (ev_rx) begin
            rp = 1'b1; rs = 1'b1; srx = 1'b1; act = ACT_RX;
        end
        if (ev_rd) begin
            rp = 1'b0; rs = 1'b0; srx = 1'b0; act = ACT_IDLE;
            if (tp) begin
                ts = 1'b1; act = ACT_TX;
                if (tx_ie) stx = 1'b1;
            end
        end
        if (ev_wr) begin
            tp = 1'b0;
        end
        if (ev_txe) begin
            tp = 1'b1;
            if (!rs) begin
                ts = 1'b1; act = ACT_TX;
                if (tx_ie) stx = 1'b1;
            end
        end
        if (ev_cmd) begin
            if (cmd == CMD_CLR_TX) begin
                tp = 1'b0; ts = 1'b0; stx = 1'b0; act = ACT_IDLE;
                if (rp) begin
                    rs = 1'b1; srx = 1'b1; act = ACT_RX;
                end
            end else if (cmd == CMD_RST_IUS) begin
                if (rs) begin
                    rs = 1'b0;
                    if (tp) begin
                        ts = 1'b1; act = ACT_TX;
                        if (tx_ie) stx = 1'b1;
                    end
                end else if (ts) begin
                    ts = 1'b0;
                end
            end
        end
    end

    // Request term from next-state flags and current enables.
    always_comb begin
        req_nxt = (tx_ie && tp)
               || (((rx_mode == 2'b01) || (rx_mode == 2'b10)) && rp)
               || (brk_ie && brk);
    end

    // Flag and summary-bit registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_pend_q <= 1'b0; rx_svc_q <= 1'b0;
            tx_pend_q <= 1'b0; tx_svc_q <= 1'b0;
            sum_rx    <= 1'b0; sum_tx   <= 1'b0;
        end else begin
            rx_pend_q <= rp;  rx_svc_q <= rs;
            tx_pend_q <= tp;  tx_svc_q <= ts;
            sum_rx    <= srx; sum_tx   <= stx;
        end
    end
endmodule

// File: rtl/irq_vec_sel.sv
// Shared vector register. Picks one channel's action per cycle: a presentation
// by A, then by B, then a clear by A, then by B. Assumes two channels.
module irq_vec_sel
    import dual_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  vec_act_t         act_a,
    input  vec_act_t         act_b,
    input  logic             hi,
    output logic [VEC_W-1:0] vec_q
);
    logic             upd;
    logic [VEC_W-1:0] nxt;

    // Priority choice of the winning action.
    always_comb begin
        upd = 1'b1;
        if ((act_a == ACT_RX) || (act_a == ACT_TX))      nxt = vec_code(1'b0, act_a, hi);
        else if ((act_b == ACT_RX) || (act_b == ACT_TX)) nxt = vec_code(1'b1, act_b, hi);
        else if (act_a == ACT_IDLE)                      nxt = vec_code(1'b0, act_a, hi);
        else if (act_b == ACT_IDLE)                      nxt = vec_code(1'b1, act_b, hi);
        else begin
            upd = 1'b0;
            nxt = vec_q;
        end
    end

    // Vector register.
    always_ff @(posedge clk) begin
        if (!rst_n)   vec_q <= '0;
        else if (upd) vec_q <= nxt;
    end
endmodule

// File: rtl/dual_irq_ctrl.sv
// Top of the dual-channel interrupt controller: one state block per channel,
// the shared vector register, the summary byte and the registered irq line.
// Assumes configuration inputs come from an external register file.
module dual_irq_ctrl
    import dual_irq_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCH-1:0]          rx_byte_ev,
    input  logic [NCH-1:0]          data_rd_ev,
    input  logic [NCH-1:0]          data_wr_ev,
    input  logic [NCH-1:0]          tx_empty_ev,
    input  logic [NCH-1:0]          cmd_wr,
    input  logic [CMD_W-1:0]        cmd_code,
    input  logic [NCH-1:0]          tx_int_en,
    input  logic [NCH*MODE_W-1:0]   rx_int_mode,
    input  logic [NCH-1:0]          brk_int_en,
    input  logic [NCH-1:0]          brk_status,
    input  logic                    vec_status_hi,
    output logic                    irq,
    output logic [SUM_W-1:0]        int_summary,
    output logic [VEC_W-1:0]        int_vector
);
    vec_act_t       act [NCH];
    logic [NCH-1:0] req_nxt, sum_rx, sum_tx;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        irq_chan_state u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .ev_rx   (rx_byte_ev[c]),
            .ev_rd   (data_rd_ev[c]),
            .ev_wr   (data_wr_ev[c]),
            .ev_txe  (tx_empty_ev[c]),
            .ev_cmd  (cmd_wr[c]),
            .cmd     (cmd_code),
            .tx_ie   (tx_int_en[c]),
            .rx_mode (rx_int_mode[MODE_W*c +: MODE_W]),
            .brk_ie  (brk_int_en[c]),
            .brk     (brk_status[c]),
            .act     (act[c]),
            .req_nxt (req_nxt[c]),
            .sum_rx  (sum_rx[c]),
            .sum_tx  (sum_tx[c])
        );
    end

    irq_vec_sel u_vec (
        .clk   (clk),
        .rst_n (rst_n),
        .act_a (act[0]),
        .act_b (act[1]),
        .hi    (vec_status_hi),
        .vec_q (int_vector)
    );

    // Place per-channel summary bits at their fixed positions.
    always_comb begin
        int_summary = '0;
        for (int c = 0; c < NCH; c++) begin
            int_summary[SUM_RX_BIT[c]] = sum_rx[c];
            int_summary[SUM_TX_BIT[c]] = sum_tx[c];
        end
    end

    // Registered shared interrupt line.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |req_nxt;
    end
endmodule

// File: rtl/dual_irq_ctrl_chk.sv
// Property checker for dual_irq_ctrl, attached with bind below.
module dual_irq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_a,
    input logic       rd_a,
    input logic       wr_a,
    input logic       txe_a,
    input logic       cmd_a,
    input logic [1:0] tx_en,
    input logic [3:0] rx_mode,
    input logic [1:0] brk_en,
    input logic       vec_hi,
    input logic       irq,
    input logic [1:0] sum_a,
    input logic [7:0] vec
);
    logic seen;
    logic all_masked;

    // Marks the cycles after the first edge out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    assign all_masked = (tx_en == 2'b00) && (brk_en == 2'b00)
                     && (rx_mode[1:0] == 2'b00 || rx_mode[1:0] == 2'b11)
                     && (rx_mode[3:2] == 2'b00 || rx_mode[3:2] == 2'b11);

    // R12
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seen |-> (!irq && sum_a == 2'b00 && vec == 8'h00));

    // R1
    masked_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        all_masked |=> !irq);

    // R2
    rx_a_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_a && !rd_a && !cmd_a) |=>
            (sum_a[1] && vec == ($past(vec_hi) ? 8'h30 : 8'h0C)));

    // R4
    tx_sum_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sum_a[0]) |-> $past(tx_en[0]));

    // R9
    wr_keeps_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_a && !rx_a && !rd_a && !txe_a && !cmd_a) |=> $stable(sum_a));
endmodule

bind dual_irq_ctrl dual_irq_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_a    (rx_byte_ev[0]),
    .rd_a    (data_rd_ev[0]),
    .wr_a    (data_wr_ev[0]),
    .txe_a   (tx_empty_ev[0]),
    .cmd_a   (cmd_wr[0]),
    .tx_en   (tx_int_en),
    .rx_mode (rx_int_mode),
    .brk_en  (brk_int_en),
    .vec_hi  (vec_status_hi),
    .irq     (irq),
    .sum_a   (int_summary[5:4]),
    .vec     (int_vector)
);

// File: tb/tb_dual_irq_ctrl.sv
`timescale 1ns/1ps
module tb_dual_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] rx_byte_ev = '0, data_rd_ev = '0, data_wr_ev = '0;
    logic [1:0] tx_empty_ev = '0, cmd_wr = '0;
    logic [2:0] cmd_code = '0;
    logic [1:0] tx_int_en = '0, brk_int_en = '0, brk_status = '0;
    logic [3:0] rx_int_mode = '0;
    logic       vec_status_hi = 1'b0;
    logic       irq;
    logic [7:0] int_summary, int_vector;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dual_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .rx_byte_ev(rx_byte_ev), .data_rd_ev(data_rd_ev),
        .data_wr_ev(data_wr_ev), .tx_empty_ev(tx_empty_ev), .cmd_wr(cmd_wr),
        .cmd_code(cmd_code), .tx_int_en(tx_int_en), .rx_int_mode(rx_int_mode),
        .brk_int_en(brk_int_en), .brk_status(brk_status),
        .vec_status_hi(vec_status_hi), .irq(irq), .int_summary(int_summary),
        .int_vector(int_vector)
    );

    // Fields: rx rd wr txe cmdw (2 each, bit0=A) | cmd 3 | req 4 | irq | sum | vec
    localparam int NV = 13;
    localparam logic [33:0] VT [NV] = '{
        {2'b01,2'b00,2'b00,2'b00,2'b00,3'b000,4'd2, 1'b1,8'h20,8'h30}, // R2 A rx
        {2'b00,2'b00,2'b00,2'b01,2'b00,3'b000,4'd3, 1'b1,8'h20,8'h30}, // R3 tx blocked
        {2'b00,2'b00,2'b00,2'b00,2'b01,3'b111,4'd6, 1'b1,8'h30,8'h10}, // R6 reset IUS
        {2'b00,2'b01,2'b00,2'b00,2'b00,3'b000,4'd8, 1'b1,8'h10,8'h10}, // R8 read
        {2'b00,2'b00,2'b00,2'b00,2'b01,3'b101,4'd7, 1'b0,8'h00,8'h60}, // R7 clr tx
        {2'b10,2'b00,2'b00,2'b00,2'b00,3'b000,4'd2, 1'b1,8'h04,8'h20}, // R2 B rx
        {2'b00,2'b00,2'b00,2'b10,2'b00,3'b000,4'd3, 1'b1,8'h04,8'h20}, // R3 B blocked
        {2'b00,2'b10,2'b00,2'b00,2'b00,3'b000,4'd8, 1'b1,8'h02,8'h00}, // R8 B tx shown
        {2'b00,2'b00,2'b10,2'b00,2'b00,3'b000,4'd9, 1'b0,8'h02,8'h00}, // R9 write
        {2'b00,2'b00,2'b00,2'b00,2'b10,3'b111,4'd6, 1'b0,8'h02,8'h00}, // R6 tx svc clr
        {2'b01,2'b00,2'b00,2'b01,2'b00,3'b000,4'd10,1'b1,8'h22,8'h30}, // R10 rx first
        {2'b00,2'b00,2'b00,2'b00,2'b01,3'b101,4'd7, 1'b1,8'h22,8'h30}, // R7 re-present rx
        {2'b10,2'b01,2'b00,2'b00,2'b00,3'b000,4'd11,1'b1,8'h06,8'h20}  // R11 B over A clear
    };

    task automatic check(input int req, input logic ei, input logic [7:0] es,
                         input logic [7:0] ev);
        n_chk++;
        if (irq !== ei || int_summary !== es || int_vector !== ev) begin
            n_fail++;
            $display("FAIL R%0d: irq/sum/vec = %0b/%02h/%02h expected %0b/%02h/%02h",
                     req, irq, int_summary, int_vector, ei, es, ev);
        end
    endtask

    // Drive one cycle of strobes at a falling edge, sample at the next one.
    task automatic cyc(input logic [1:0] rx, input logic [1:0] rd, input logic [1:0] wr,
                       input logic [1:0] txe, input logic [1:0] cw, input logic [2:0] cmd);
        rx_byte_ev = rx; data_rd_ev = rd; data_wr_ev = wr;
        tx_empty_ev = txe; cmd_wr = cw; cmd_code = cmd;
        @(negedge clk);
        rx_byte_ev = '0; data_rd_ev = '0; data_wr_ev = '0;
        tx_empty_ev = '0; cmd_wr = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        @(negedge clk);
        tx_int_en = 2'b11; rx_int_mode = 4'b0101; vec_status_hi = 1'b1;
        do_reset();
        check(12, 1'b0, 8'h00, 8'h00); // R12
        for (int i = 0; i < NV; i++) begin
            cyc(VT[i][33:32], VT[i][31:30], VT[i][29:28], VT[i][27:26],
                VT[i][25:24], VT[i][23:21]);
            check(int'(VT[i][20:17]), VT[i][16], VT[i][15:8], VT[i][7:0]);
        end

        // Directed: low encoding, tx disabled, A receive mode 11.
        tx_int_en = 2'b00; rx_int_mode = 4'b0111; vec_status_hi = 1'b0;
        do_reset();
        @(negedge clk);
        check(12, 1'b0, 8'h00, 8'h00);                           // R12
        cyc(2'b01, 2'b00, 2'b00, 2'b00, 2'b00, 3'b000);
        check(1, 1'b0, 8'h20, 8'h0C);                            // R1 mode 11, R5
        cyc(2'b00, 2'b00, 2'b00, 2'b01, 2'b00, 3'b000);
        check(1, 1'b0, 8'h20, 8'h0C);                            // R1 tx disabled
        cyc(2'b00, 2'b00, 2'b00, 2'b00, 2'b01, 3'b111);
        check(4, 1'b0, 8'h20, 8'h08);                            // R4 no tx bit
        cyc(2'b00, 2'b00, 2'b00, 2'b00, 2'b01, 3'b101);
        check(7, 1'b0, 8'h20, 8'h0C);                            // R7 rx again
        cyc(2'b00, 2'b01, 2'b00, 2'b00, 2'b00, 3'b000);
        check(5, 1'b0, 8'h00, 8'h06);                            // R5 cleared code
        cyc(2'b10, 2'b00, 2'b00, 2'b00, 2'b00, 3'b000);
        check(5, 1'b1, 8'h04, 8'h04);                            // R5 B rx low
        cyc(2'b00, 2'b10, 2'b00, 2'b00, 2'b00, 3'b000);
        check(8, 1'b0, 8'h00, 8'h06);                            // R8
        rx_int_mode = 4'b1011;
        cyc(2'b10, 2'b00, 2'b00, 2'b00, 2'b00, 3'b000);
        check(1, 1'b1, 8'h04, 8'h04);                            // R1 mode 10
        cyc(2'b00, 2'b10, 2'b00, 2'b00, 2'b00, 3'b000);
        check(1, 1'b0, 8'h00, 8'h06);
        brk_status = 2'b10;
        cyc(2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 3'b000);
        check(1, 1'b0, 8'h00, 8'h06);                            // R1 break masked
        brk_int_en = 2'b10;
        cyc(2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 3'b000);
        check(1, 1'b1, 8'h00, 8'h06);                            // R1 break request
        brk_status = 2'b00;
        cyc(2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 3'b000);
        check(1, 1'b0, 8'h00, 8'h06);
        tx_int_en = 2'b01;
        cyc(2'b00, 2'b00, 2'b00, 2'b01, 2'b00, 3'b000);
        check(3, 1'b1, 8'h10, 8'h08);                            // R3 presented
        cyc(2'b00, 2'b00, 2'b01, 2'b00, 2'b00, 3'b000);
        check(9, 1'b0, 8'h10, 8'h08);                            // R9
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule